// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flags

This block performs one 8-bit arithmetic or logic operation per accepted request. A request carries an opcode, the working-register operand, a second operand (a file value or a literal), and a destination bit. The block keeps the five status flags in its own status register. The carry-in for the carry and borrow forms comes from that stored carry. Each accepted request rewrites only the flags that its opcode owns.

The result, the resolved destination and the status after the operation are held in a single output stage. The request side follows valid/ready rules. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output stage is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output stays frozen and no new request enters. Back-to-back requests each see the status left by the request before them.

Top module: `byte_alu`

## Requirements
- R1: Request acceptance and output handshake.
  - A request is accepted on a rising edge where `in_valid` and `in_ready` are both high.
  - `in_ready` equals `!out_valid || out_ready`.
  - The result is presented with `out_valid` high one cycle after acceptance.
  - While `out_valid` is high and `out_ready` is low, `out_result`, `out_to_file` and `out_flags` stay unchanged.
- R2: Addition.
  - Opcode 0 gives w+b.
  - Opcode 13 (literal add) gives w+b.
  - Opcode 1 gives w+b+C, where C is the stored carry.
- R3: Subtraction.
  - Opcode 2 (literal subtract) gives b-w.
  - Opcode 3 gives b-w.
  - Opcode 4 gives w-b-borrow.
  - Opcode 5 gives b-w-borrow.
  - In both borrow forms, borrow is the inverse of the stored C.
- R4: Increment, decrement and negate: opcode 6 gives b+1, opcode 7 gives b-1, and opcode 9 gives the two's complement of b.
- R5: Logic and constant operations.
  - Opcode 8 gives ~b.
  - Opcode 12 swaps the 4-bit halves of b.
  - Opcode 10 gives 0x00.
  - Opcode 11 gives 0xFF.
- R6: Flag encoding for the arithmetic opcodes (0–7, 9, 13). `out_flags` is {N,OV,Z,DC,C} (bit 4 down to bit 0), and these opcodes rewrite all five flags:
  - N is result bit 7.
  - Z is 1 for a zero result.
  - OV is signed two's-complement overflow.
  - C is the carry out of bit 7. For subtraction it is 1 when no borrow occurred.
  - DC is the same carry or no-borrow, taken out of bit 3.
- R7: Adding 0x4F and 0x48 yields 0x97 with `out_flags` = 5'b11010.
- R8: Partial flag updates.
  - Opcode 8 rewrites only N and Z.
  - Opcode 10 sets Z to 1 and keeps the other flags.
  - Opcodes 11 and 12 leave all flags unchanged.
- R9: Destination.
  - `in_dest` 0 sends the result to the working register (`out_to_file`=0), and 1 sends it to the file (`out_to_file`=1).
  - Opcodes 2 and 13 always target the working register.
  - Opcodes 9, 10 and 11 always target the file.
- R10: Opcodes 14 and 15 pass b through unchanged, keep all flags, and honour `in_dest`.
- R11: After reset, `out_valid` is 0, all flags are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_op | input | 4 | Opcode |
| in_w | input | 8 | Working-register operand |
| in_b | input | 8 | File or literal operand |
| in_dest | input | 1 | Requested destination (0 working, 1 file) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Operation result |
| out_to_file | output | 1 | Resolved destination |
| out_flags | output | 5 | Status {N,OV,Z,DC,C} after the operation |

## Verification
The hardest case to reach from the ports is a borrow or carry-chained operation that depends on a specific stored carry. Reaching it needs a prior operation that sets or clears C, followed by the dependent one. The stimulus uses directed pairs to create this case: an add that overflows, then an add-with-carry, and a borrow-producing subtract, then each borrow form. Long random sequences then chain whatever carry each operation leaves. A stalled output stage holding one result while a different request waits is forced by dropping `out_ready` across several cycles.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUBL  = 4'd2,
    OP_SUB   = 4'd3,
    OP_SUBWB = 4'd4,
    OP_SUBFB = 4'd5,
    OP_INC   = 4'd6,
    OP_DEC   = 4'd7,
    OP_COM   = 4'd8,
    OP_NEG   = 4'd9,
    OP_CLR   = 4'd10,
    OP_SET   = 4'd11,
    OP_SWAP  = 4'd12,
    OP_ADDL  = 4'd13,
    OP_RSV0  = 4'd14,
    OP_RSV1  = 4'd15
  } alu_op_e;

  localparam int NFLAGS = 5;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;
endpackage

// File: rtl/byte_alu_datapath.sv
module byte_alu_datapath
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] w,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output flags_t           aflags,
  output logic             is_arith
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] x, y;
  logic             ci;
  logic [WIDTH:0]   full;
  logic [HALF:0]    low;
  logic [WIDTH-1:0] lres;

  // operand steering: subtraction as x + ~y + no-borrow
  always_comb begin
    x = b;
    y = '0;
    ci = 1'b0;
    is_arith = 1'b1;
    case (op)
      OP_ADD, OP_ADDL: begin x = w; y = b; end
      OP_ADDC:         begin x = w; y = b; ci = cin; end
      OP_SUBL, OP_SUB: begin x = b; y = ~w; ci = 1'b1; end
      OP_SUBWB:        begin x = w; y = ~b; ci = cin; end
      OP_SUBFB:        begin x = b; y = ~w; ci = cin; end
      OP_INC:          begin x = b; y = '0; ci = 1'b1; end
      OP_DEC:          begin x = b; y = '1; end
      OP_NEG:          begin x = '0; y = ~b; ci = 1'b1; end
      default:         is_arith = 1'b0;
    endcase
  end

  assign full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  assign low  = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, ci};

  always_comb begin
    case (op)
      OP_COM:  lres = ~b;
      OP_CLR:  lres = '0;
      OP_SET:  lres = '1;
      OP_SWAP: lres = {b[HALF-1:0], b[WIDTH-1:HALF]};
      default: lres = b;
    endcase
  end

  assign res       = is_arith ? full[WIDTH-1:0] : lres;
  assign aflags.n  = full[WIDTH-1];
  assign aflags.z  = (full[WIDTH-1:0] == '0);
  assign aflags.c  = full[WIDTH];
  assign aflags.dc = low[HALF];
  assign aflags.ov = (x[WIDTH-1] == y[WIDTH-1]) && (full[WIDTH-1] != x[WIDTH-1]);
endmodule

// File: rtl/byte_alu_ctrl.sv
module byte_alu_ctrl
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic             dest_req,
  input  logic [WIDTH-1:0] res,
  input  flags_t           aflags,
  input  logic             is_arith,
  input  flags_t           st_q,
  output flags_t           st_d,
  output logic             to_file
);
  always_comb begin
    st_d = st_q;
    if (is_arith) begin
      st_d = aflags;
    end else begin
      case (op)
        OP_COM: begin
          st_d.n = res[WIDTH-1];
          st_d.z = (res == '0);
        end
        OP_CLR:  st_d.z = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (op)
      OP_SUBL, OP_ADDL:        to_file = 1'b0;
      OP_NEG, OP_CLR, OP_SET:  to_file = 1'b1;
      default:                 to_file = dest_req;
    endcase
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       in_op,
  input  logic [WIDTH-1:0] in_w,
  input  logic [WIDTH-1:0] in_b,
  input  logic             in_dest,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic             out_to_file,
  output logic [NFLAGS-1:0] out_flags
);
  alu_op_e          op;
  logic [WIDTH-1:0] res;
  flags_t           aflags, st_q, st_d;
  logic             is_arith, to_file, take;

  assign op       = alu_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  byte_alu_datapath #(.WIDTH(WIDTH)) dp_i (
    .op(op), .w(in_w), .b(in_b), .cin(st_q.c),
    .res(res), .aflags(aflags), .is_arith(is_arith)
  );

  byte_alu_ctrl #(.WIDTH(WIDTH)) ctl_i (
    .op(op), .dest_req(in_dest), .res(res), .aflags(aflags),
    .is_arith(is_arith), .st_q(st_q), .st_d(st_d), .to_file(to_file)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_to_file <= 1'b0;
      st_q        <= '0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_result  <= res;
        out_to_file <= to_file;
        st_q        <= st_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_flags = st_q;
endmodule

// File: rtl/byte_alu_checker.sv
module byte_alu_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_op,
  input logic [WIDTH-1:0] in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic             out_to_file,
  input logic [4:0]       out_flags
);
  localparam int HALF = WIDTH / 2;
  logic take;
  assign take = in_valid && in_ready;

  AST_TAKE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
      && $stable(out_flags) && $stable(out_to_file))); // R1
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 4'd10) |=> (out_result == '0 && out_flags[2] && out_to_file)); // R8
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 4'd11) |=> (out_result == '1 && out_flags == $past(out_flags))); // R8
  AST_LIT_TO_W: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_op == 4'd2 || in_op == 4'd13)) |=> !out_to_file); // R9
  AST_SWAP_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 4'd12) |=> (out_result == {$past(in_b[HALF-1:0]), $past(in_b[WIDTH-1:HALF])})); // R5
  AST_ARITH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_op <= 4'd7 || in_op == 4'd9 || in_op == 4'd13))
      |=> (out_flags[2] == (out_result == '0)) && (out_flags[4] == out_result[WIDTH-1])); // R6
endmodule

bind byte_alu byte_alu_checker #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_to_file(out_to_file), .out_flags(out_flags)
);

// File: tb/byte_alu_tb_top.sv
`timescale 1ns/1ps
module byte_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ready, in_dest = 1'b0;
  logic [3:0] in_op = '0;
  logic [7:0] in_w = '0, in_b = '0;
  logic       out_valid, out_ready = 1'b1, out_to_file;
  logic [7:0] out_result;
  logic [4:0] out_flags;
  logic [4:0] st = '0;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  byte_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_w(in_w), .in_b(in_b), .in_dest(in_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_to_file(out_to_file), .out_flags(out_flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 1, 13: return "R2 R6 R9";
      2, 3, 4, 5: return "R3 R6 R9";
      6, 7, 9: return "R4 R6 R9";
      8, 10, 11, 12: return "R5 R8 R9";
      default: return "R10";
    endcase
  endfunction

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {result[7:0], to_file, flags{N,OV,Z,DC,C}}
  function automatic logic [13:0] ref_op(input int op, input int w, input int b,
                                         input logic d, input logic [4:0] s);
    int x, y, k, r, lo, sv;
    bit sub, ar;
    logic [7:0] res;
    logic [4:0] f;
    logic tf;
    ar = 1; sub = 0; x = 0; y = 0; k = 0;
    case (op)
      0, 13: begin x = w; y = b; end
      1:     begin x = w; y = b; k = s[0]; end
      2, 3:  begin sub = 1; x = b; y = w; end
      4:     begin sub = 1; x = w; y = b; k = !s[0]; end
      5:     begin sub = 1; x = b; y = w; k = !s[0]; end
      6:     begin x = b; y = 1; end
      7:     begin sub = 1; x = b; y = 1; end
      9:     begin sub = 1; x = 0; y = b; end
      default: ar = 0;
    endcase
    f = s;
    if (ar) begin
      if (sub) begin
        r = x - y - k; lo = (x % 16) - (y % 16) - k; sv = sgn(x) - sgn(y) - k;
        f[0] = (r >= 0); f[1] = (lo >= 0);
      end else begin
        r = x + y + k; lo = (x % 16) + (y % 16) + k; sv = sgn(x) + sgn(y) + k;
        f[0] = (r > 255); f[1] = (lo > 15);
      end
      res = r[7:0];
      f[3] = (sv > 127) || (sv < -128);
      f[4] = res[7]; f[2] = (res == 0);
    end else begin
      case (op)
        8:  begin res = ~b[7:0]; f[4] = res[7]; f[2] = (res == 0); end
        10: begin res = 8'h00; f[2] = 1'b1; end
        11: res = 8'hFF;
        12: res = {b[3:0], b[7:4]};
        default: res = b[7:0];
      endcase
    end
    case (op)
      2, 13: tf = 1'b0;
      9, 10, 11: tf = 1'b1;
      default: tf = d;
    endcase
    return {res, tf, f};
  endfunction

  task automatic do_op(input int op, input int w, input int b, input logic d);
    logic [13:0] e;
    @(negedge clk);
    in_op = op[3:0]; in_w = w[7:0]; in_b = b[7:0]; in_dest = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    e = ref_op(op, w, b, d, st);
    st = e[4:0];
    chk({tag_of(op), " valid R1"}, {31'd0, out_valid}, 32'd1);
    chk(tag_of(op), {18'd0, out_result, out_to_file, out_flags}, {18'd0, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [13:0] ea, eb;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R11 flags", {27'd0, out_flags}, 32'd0);
    chk("R11 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    do_op(0, 8'h4F, 8'h48, 1'b0);                 // R7 worked example
    chk("R7 example", {19'd0, out_result, out_flags}, {19'd0, 8'h97, 5'b11010});
    do_op(0, 8'hFF, 8'h01, 1'b1);                 // sets carry
    do_op(1, 8'h01, 8'h01, 1'b0);                 // R2 add with carry -> 3
    do_op(2, 8'h01, 8'h00, 1'b1);                 // R3 literal subtract, borrow
    do_op(4, 8'h10, 8'h01, 1'b1);                 // R3 borrow form with C=0
    do_op(5, 8'h01, 8'h10, 1'b0);
    do_op(7, 0, 8'h00, 1'b1);                     // R4 decrement of zero
    do_op(9, 0, 8'h80, 1'b0);                     // R4 negate of 0x80
    do_op(8, 0, 8'hFF, 1'b1);                     // R8 complement to zero
    do_op(10, 0, 8'h55, 1'b0);                    // R8 clear
    do_op(11, 0, 8'h00, 1'b0);                    // R8 set keeps flags
    do_op(12, 0, 8'hA5, 1'b1);                    // R5 swap
    do_op(14, 0, 8'h3C, 1'b1);                    // R10 pass-through
    do_op(15, 0, 8'hC3, 1'b0);

    for (int i = 0; i < 400; i++)
      do_op($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255), 1'($urandom_range(0, 1)));

    // R1 back-pressure: stall output while a second request waits
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 4'd0; in_w = 8'h11; in_b = 8'h22; in_dest = 1'b1; in_valid = 1'b1;
    ea = ref_op(0, 8'h11, 8'h22, 1'b1, st); st = ea[4:0];
    @(negedge clk);
    in_op = 4'd12; in_b = 8'h3C; in_dest = 1'b0;
    for (int j = 0; j < 3; j++) begin
      chk("R1 stall ready", {31'd0, in_ready}, 32'd0);
      chk("R1 stall hold", {17'd0, out_valid, out_result, out_to_file, out_flags},
          {17'd0, 1'b1, ea});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    eb = ref_op(12, 0, 8'h3C, 1'b0, st); st = eb[4:0];
    chk("R1 after stall", {18'd0, out_result, out_to_file, out_flags}, {18'd0, eb});
    @(negedge clk);
    chk("R1 drained", {31'd0, out_valid}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule